// File: doc/BRIEF.md
# Dual-Channel Receive Output Formatter

This block sits between two receive sample streams (channel A and channel B) and a downstream digital device. Both channels are sampled on a shared sample strobe. The strobe either fires on every input clock or on every second one. On each kept strobe the block captures one sample pair and places it on its output interface. In parallel mode each channel has its own output bus. In multiplexed mode the channel A bus carries both channels, one after the other, and a channel-identity flag tells the receiver which channel is present. A decimation option keeps only every second pair, which halves the output word rate by simple dropping.

The block also drives a qualifying clock for the receiver. This clock either follows the input clock or runs at half its rate, and its polarity can be flipped so that the receiver latches on the opposite edge. All registers use one input clock and a synchronous active-high reset.

Top module: `rx_out_fmt`

## Requirements
- R1: With `adc_div2` low, a sample strobe occurs on every clock. With `adc_div2` high, it occurs on every second clock, starting with the first rising edge after reset is released.
- R2: With `dec_en` high, only every second strobe captures a pair, starting with the first strobe after reset. Pairs that are dropped leave the outputs unchanged.
- R3: In parallel mode (`mux_en` low), `out_a` and `out_b` show the captured `ch_a` and `ch_b` values from the clock after the capturing edge, and they hold until the next capture.
- R4: In multiplexed mode, the channel A word of a captured pair appears on `out_a` first. The channel B word of the same pair follows on the next clock. `out_b` reads zero throughout multiplexed mode.
- R5: `sync` changes in the same cycle as `out_a`. With `sync_inv` low it is 1 while a channel A word is on the bus and 0 while a channel B word is on it. In parallel mode it stays at the channel B level.
- R6: With `sync_inv` high, both levels of `sync` are swapped.
- R7: If a new pair is captured in the same cycle that a pending channel B word would be emitted, the new channel A word takes the bus and the pending B word is discarded.
- R8: With `clk_sel` high, `oclk` follows the input clock. With `clk_sel` low, `oclk` runs at half rate. Before inversion it is low until the first rising edge after reset release, and it then toggles on every rising edge.
- R9: With `clk_inv` high, `oclk` is the complement of the R8 waveform.
- R10: While `rst` is high at a rising edge, the outputs clear to zero, `sync` goes to its channel B level, and the strobe, decimation and clock-divider phases restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_div2 | input | 1 | Sample strobe at half clock rate when high |
| dec_en | input | 1 | Keep every second sample pair |
| mux_en | input | 1 | Interleave both channels onto `out_a` |
| sync_inv | input | 1 | Swap polarity of `sync` |
| clk_sel | input | 1 | Qualifying clock at full rate when high, half rate when low |
| clk_inv | input | 1 | Invert qualifying clock |
| ch_a | input | W | Channel A sample |
| ch_b | input | W | Channel B sample |
| out_a | output | W | Channel A bus, or interleaved bus in multiplexed mode |
| out_b | output | W | Channel B bus, zero in multiplexed mode |
| sync | output | 1 | Channel identity flag aligned with `out_a` |
| oclk | output | 1 | Qualifying clock for the receiver |

## Verification
The key collision is a fresh pair capture landing in the same cycle that the previous pair's channel B word is due. This is forced by enabling multiplexed mode with both `adc_div2` and `dec_en` low, so that every clock captures a pair. The bench then expects `out_a` to follow `ch_a` on every cycle, with `sync` fixed at the channel A level and no B word ever appearing. The same reference model also runs the non-colliding multiplexed cases, where the B word must appear exactly one clock after its A word.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOAD   = 2'd1,
    ACT_EMIT_B = 2'd2
  } word_act_e;

  // strobe fires every clock, or on the even phase when halved
  function automatic logic strobe_due(input logic div2, input logic ph);
    return !div2 || !ph;
  endfunction

  // decimation keeps the strobe whose keep-phase is even
  function automatic logic pair_kept(input logic dec, input logic kph);
    return !dec || !kph;
  endfunction

  // identity flag level for the word on the bus
  function automatic logic sync_level(input logic is_a, input logic inv);
    return is_a ^ inv;
  endfunction

  // qualifying clock level
  function automatic logic qclk_level(input logic sel, input logic clk_lvl,
                                      input logic div_ph, input logic inv);
    return (sel ? clk_lvl : div_ph) ^ inv;
  endfunction

endpackage

// File: rtl/rxf_strobe_gen.sv
module rxf_strobe_gen
  import rxf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adc_div2,
  input  logic dec_en,
  output logic strobe,
  output logic take
);

  logic ph_q;
  logic kph_q;

  assign strobe = strobe_due(adc_div2, ph_q);
  assign take   = strobe && pair_kept(dec_en, kph_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= 1'b0;
      kph_q <= 1'b0;
    end else begin
      ph_q <= ~ph_q;
      if (strobe) kph_q <= ~kph_q;
    end
  end

endmodule

// File: rtl/rxf_clk_out.sv
module rxf_clk_out
  import rxf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clk_sel,
  input  logic clk_inv,
  output logic oclk,
  output logic div_ph
);

  logic cph_q;

  always_ff @(posedge clk) begin
    if (rst) cph_q <= 1'b0;
    else     cph_q <= ~cph_q;
  end

  assign div_ph = cph_q;
  assign oclk   = qclk_level(clk_sel, clk, cph_q, clk_inv);

endmodule

// File: rtl/rxf_word_path.sv
module rxf_word_path
  import rxf_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic         mux_en,
  input  logic [W-1:0] ch_a,
  input  logic [W-1:0] ch_b,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b,
  output logic         word_is_a,
  output logic         b_pending,
  output word_act_e    act
);

  localparam logic [W-1:0] ZW = '0;

  logic [W-1:0] hold_b_q;
  logic [W-1:0] oa_q;
  logic [W-1:0] ob_q;
  logic         isa_q;
  logic         pend_q;

  always_comb begin
    if (take)                  act = ACT_LOAD;
    else if (pend_q && mux_en) act = ACT_EMIT_B;
    else                       act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oa_q     <= ZW;
      ob_q     <= ZW;
      hold_b_q <= ZW;
      isa_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      unique case (act)
        ACT_LOAD: begin
          oa_q <= ch_a;
          if (mux_en) begin
            ob_q     <= ZW;
            hold_b_q <= ch_b;
            isa_q    <= 1'b1;
            pend_q   <= 1'b1;
          end else begin
            ob_q   <= ch_b;
            isa_q  <= 1'b0;
            pend_q <= 1'b0;
          end
        end
        ACT_EMIT_B: begin
          oa_q   <= hold_b_q;
          ob_q   <= ZW;
          isa_q  <= 1'b0;
          pend_q <= 1'b0;
        end
        default: begin
          if (mux_en) begin
            ob_q <= ZW;
          end else begin
            isa_q  <= 1'b0;
            pend_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign out_a     = oa_q;
  assign out_b     = ob_q;
  assign word_is_a = isa_q;
  assign b_pending = pend_q;

endmodule

// File: rtl/rx_out_fmt.sv
module rx_out_fmt
  import rxf_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adc_div2,
  input  logic         dec_en,
  input  logic         mux_en,
  input  logic         sync_inv,
  input  logic         clk_sel,
  input  logic         clk_inv,
  input  logic [W-1:0] ch_a,
  input  logic [W-1:0] ch_b,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b,
  output logic         sync,
  output logic         oclk
);

  // internal events brought out for the checker
  logic      strobe;
  logic      take;
  logic      word_is_a;
  logic      b_pending;
  logic      div_ph;
  word_act_e act;

  rxf_strobe_gen u_strobe (
    .clk      (clk),
    .rst      (rst),
    .adc_div2 (adc_div2),
    .dec_en   (dec_en),
    .strobe   (strobe),
    .take     (take)
  );

  rxf_word_path #(.W(W)) u_path (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .mux_en    (mux_en),
    .ch_a      (ch_a),
    .ch_b      (ch_b),
    .out_a     (out_a),
    .out_b     (out_b),
    .word_is_a (word_is_a),
    .b_pending (b_pending),
    .act       (act)
  );

  rxf_clk_out u_clk (
    .clk     (clk),
    .rst     (rst),
    .clk_sel (clk_sel),
    .clk_inv (clk_inv),
    .oclk    (oclk),
    .div_ph  (div_ph)
  );

  assign sync = sync_level(word_is_a, sync_inv);

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         adc_div2,
  input logic         mux_en,
  input logic [W-1:0] ch_a,
  input logic [W-1:0] ch_b,
  input logic [W-1:0] out_a,
  input logic [W-1:0] out_b,
  input logic         strobe,
  input logic         take,
  input logic         word_is_a,
  input logic         b_pending
);

  AST_STROBE_HALVED: assert property (@(posedge clk) disable iff (rst)
    (adc_div2 && strobe) |=> (!adc_div2 || !strobe)); // R1

  AST_PAR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (take && !mux_en) |=> (out_a == $past(ch_a) && out_b == $past(ch_b))); // R3

  AST_MUX_A_FIRST: assert property (@(posedge clk) disable iff (rst)
    (take && mux_en) |=> (word_is_a && out_a == $past(ch_a))); // R4

  AST_B_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    mux_en |=> (out_b == '0)); // R4

  AST_B_FOLLOWS_A: assert property (@(posedge clk) disable iff (rst)
    (word_is_a && !take) |=> !word_is_a); // R5

  AST_COLLIDE_A_WINS: assert property (@(posedge clk) disable iff (rst)
    (b_pending && take && mux_en) |=> (word_is_a && out_a == $past(ch_a))); // R7

endmodule

bind rx_out_fmt rxf_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .adc_div2  (adc_div2),
  .mux_en    (mux_en),
  .ch_a      (ch_a),
  .ch_b      (ch_b),
  .out_a     (out_a),
  .out_b     (out_b),
  .strobe    (strobe),
  .take      (take),
  .word_is_a (word_is_a),
  .b_pending (b_pending)
);

// File: tb/sim_rx_out_fmt.sv
module sim_rx_out_fmt;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         adc_div2 = 1'b0, dec_en = 1'b0, mux_en = 1'b0;
  logic         sync_inv = 1'b0, clk_sel = 1'b1, clk_inv = 1'b0;
  logic [W-1:0] ch_a = '0, ch_b = '0;
  logic [W-1:0] out_a, out_b;
  logic         sync, oclk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  rx_out_fmt #(.W(W)) u0 (
    .clk(clk), .rst(rst), .adc_div2(adc_div2), .dec_en(dec_en),
    .mux_en(mux_en), .sync_inv(sync_inv), .clk_sel(clk_sel),
    .clk_inv(clk_inv), .ch_a(ch_a), .ch_b(ch_b), .out_a(out_a),
    .out_b(out_b), .sync(sync), .oclk(oclk)
  );

  // cfg bits: mux, dec, div2, sinv, csel, cinv
  localparam logic [5:0] CFG [8] = '{
    6'b000010,  // parallel, full-rate strobe
    6'b001000,  // parallel, halved strobe, half-rate clock
    6'b010011,  // parallel, decimated, inverted clock
    6'b101000,  // mux, halved strobe
    6'b101101,  // mux, halved strobe, inverted sync and clock
    6'b110010,  // mux, decimated
    6'b100010,  // mux, capture every clock (collision)
    6'b111100   // mux, decimated and halved, inverted sync
  };

  // bench reference state
  logic [W-1:0] ea, eb, eh;
  logic         eisa, ep;
  int           ncyc, nstr;

  task automatic chk(input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    ea = '0; eb = '0; eh = '0; eisa = 0; ep = 0; ncyc = 0; nstr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0;
    model_clear();
    chk("R10 out_a after reset", out_a, '0);
    chk("R10 out_b after reset", out_b, '0);
    chk("R10 sync at B level", {11'b0, sync}, {11'b0, sync_inv});
  endtask

  // one clock: drive inputs, predict, then check at the falling edge
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input string dtag);
    bit st, kp;
    ch_a = a; ch_b = b;
    st = !adc_div2 || (ncyc % 2 == 0);
    kp = st && (!dec_en || (nstr % 2 == 0));
    if (st) nstr++;
    ncyc++;
    if (kp) begin
      ea = a;
      if (mux_en) begin eh = b; ep = 1; eisa = 1; end
      else begin eb = b; ep = 0; eisa = 0; end
    end else if (ep && mux_en) begin
      ea = eh; ep = 0; eisa = 0;
    end else if (!mux_en) begin
      ep = 0; eisa = 0;
    end
    if (mux_en) eb = '0;
    @(posedge clk);
    @(negedge clk);
    chk(dtag, out_a, ea);
    chk(mux_en ? "R4 out_b zero" : "R3 out_b", out_b, eb);
    chk(sync_inv ? "R6 sync swapped" : "R5 sync", {11'b0, sync},
        {11'b0, eisa ^ sync_inv});
    chk(clk_inv ? "R9 oclk inverted" : "R8 oclk", {11'b0, oclk},
        {11'b0, (clk_sel ? 1'b0 : ncyc[0]) ^ clk_inv});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    string tg;
    for (int v = 0; v < 8; v++) begin
      {mux_en, dec_en, adc_div2, sync_inv, clk_sel, clk_inv} = CFG[v];
      do_reset();
      if (dec_en)                   tg = "R2 decimated out_a";
      else if (mux_en && !adc_div2) tg = "R7 collision out_a";
      else if (adc_div2)            tg = "R1 halved strobe out_a";
      else if (mux_en)              tg = "R4 mux out_a";
      else                          tg = "R3 parallel out_a";
      for (int c = 0; c < 12; c++)
        step(W'(12'h100 + v * 16 + c), W'(12'h800 + v * 16 + c), tg);
    end

    // R4 directed: A then B of the same pair, B bus zero
    {mux_en, dec_en, adc_div2, sync_inv, clk_sel, clk_inv} = 6'b101010;
    do_reset();
    ch_a = 12'h3A5; ch_b = 12'h5C3;
    @(posedge clk); @(negedge clk);
    chk("R4 A word first", out_a, 12'h3A5);
    chk("R5 sync high for A", {11'b0, sync}, 12'h001);
    ch_a = 12'h111; ch_b = 12'h222;
    @(posedge clk); @(negedge clk);
    chk("R4 B word of same pair", out_a, 12'h5C3);
    chk("R5 sync low for B", {11'b0, sync}, 12'h000);
    chk("R4 out_b held zero", out_b, 12'h000);

    // R10 directed: mid-run reset restarts the divider phase
    {mux_en, dec_en, adc_div2, sync_inv, clk_sel, clk_inv} = 6'b000000;
    do_reset();
    @(posedge clk); @(negedge clk);
    chk("R8 half-rate oclk after first edge", {11'b0, oclk}, 12'h001);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10 out_a cleared by reset", out_a, '0);
    chk("R10 divider phase restarted", {11'b0, oclk}, 12'h000);
    rst = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule